// File: doc/BRIEF.md
# Pipelined Burst SRAM Without Bus Turnaround

A single-clock synchronous static RAM whose address, command and write data all pass through registers, laid out so that reads and writes take the same number of clock edges. Because both paths have the same latency, a read may follow a write, or a write may follow a read, on the very next cycle. No idle cycle is ever needed on the data bus.

Each command is either loaded from the external pins or produced by an internal 2-bit burst counter. The counter steps through a 4-word group in linear or interleaved order. A write's data is captured two clock edges after its address. Meanwhile the memory array is read one edge after the address, so a read can land between a write's address and that write's data. A forwarding path merges the newest pending bytes into such a read.

A hold input suspends the whole block. A sleep input quiets the block after a fixed two-cycle delay, and another fixed two-cycle delay applies when it wakes.

Top module: `tsram_top`

## Requirements
- R1: Read latency. A read loaded or advanced on an enabled clock edge presents its word on `rdata`, with `rd_valid` high, after the second enabled edge that follows it.
- R2: Write data and lanes. A write takes `wdata` on the second enabled edge after its command edge. Only lanes whose `lane_n` bit was low on the command edge are written, where lane i is bits [8i+7:8i].
- R3: Write abort. A write command with every `lane_n` bit high leaves the memory unchanged. The burst still continues as a write.
- R4: Chip select. A load cycle (`adv` low) is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other select combination is a deselect. Later advance cycles after a deselect stay deselected and touch nothing.
- R5: Burst order. When `adv` is high, beat b of a burst (b = 1, 2, 3, then wrapping to 0) uses the loaded address with its two low bits replaced.
  - With `order_il`=0, the replacement is (start + b) mod 4.
  - With `order_il`=1, it is start XOR b.
  - The upper address bits and the operation type are kept.
  - On write beats, `lane_n` is sampled afresh.
- R6: No turnaround, newest data. Any sequence of reads and writes may be issued on consecutive cycles. Each read returns the bytes of the most recent earlier write to each lane, including a write whose data arrives after the read's address.
- R7: Clock suspend. While `hold` is high, an edge changes no state: `rdata`, `rd_valid`, the pipeline, the memory and the burst counter all keep their values.
- R8: Sleep. Two edges after `sleep` is sampled high, command inputs are ignored and `rd_valid` is low. Two edges after it is sampled low again, commands are accepted.
- R9: Reset. After reset, `rd_valid` is low and the burst state is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | High suspends every register |
| sel_a_n | input | 1 | Select, must be low to select |
| sel_b | input | 1 | Select, must be high to select |
| sel_c_n | input | 1 | Select, must be low to select |
| adv | input | 1 | High advances the burst, low loads a new command |
| wr_n | input | 1 | Low for write, high for read, on a load cycle |
| lane_n | input | LANES | Active-low byte lane write enables |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| sleep | input | 1 | Sleep request |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, taken two edges after the command |
| rdata | output | LANES*LANE_W | Registered read data |
| rd_valid | output | 1 | High while `rdata` carries a read result (bus driven) |

## Verification
The bench goes after several corner cases, each of which a faulty design would reveal.

- **Read landing between a write's address and its data.** A design without forwarding, or one that forwards whole words instead of single lanes, returns stale or overwritten bytes.
- **Write aborts and partial lane masks.** A design that ignores the lane mask corrupts bytes it should leave alone.
- **Deselected loads followed by advance cycles.** A design that lets the stale burst continue writes to memory when it must not.
- **Both burst orders with wrap.** A wrong wrap or a wrong XOR sends beats to the wrong word.
- **Hold and sleep.** Under hold, a design that leaks an edge shifts every later result by one cycle. Under sleep, a wrong delay shows up as a read result driven during sleep, or as a lost command after wake.

// File: rtl/tsram_pkg.sv
package tsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits for burst beat `beat` from start value `start`.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/tsram_burst.sv
module tsram_burst
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              asleep,
  input  logic              sel_ok,
  input  logic              adv,
  input  logic              wr_n,
  input  logic              order_il,
  input  logic [LANES-1:0]  lanes_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_be,
  output logic              ev_load,
  output logic              ev_adv
);

  op_e               burst_op;
  logic [ADDR_W-1:0] base;
  logic [1:0]        beat;
  logic [1:0]        next_beat;

  assign next_beat = beat + 2'd1;
  assign ev_load   = !asleep && !adv;
  assign ev_adv    = !asleep && adv && (burst_op != OP_IDLE);

  always_comb begin
    cmd_op   = OP_IDLE;
    cmd_addr = addr;
    if (ev_load) begin
      cmd_op = sel_ok ? (wr_n ? OP_RD : OP_WR) : OP_IDLE;
    end else if (!asleep) begin
      cmd_op   = burst_op;
      cmd_addr = {base[ADDR_W-1:2], beat_low(base[1:0], next_beat, order_il)};
    end
    cmd_be = (cmd_op == OP_WR) ? ~lanes_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_op <= OP_IDLE;
      base     <= '0;
      beat     <= '0;
    end else if (en && ev_load) begin
      burst_op <= cmd_op;
      base     <= addr;
      beat     <= '0;
    end else if (en && ev_adv) begin
      beat <= next_beat;
    end
  end

endmodule

// File: rtl/tsram_pipe.sv
module tsram_pipe
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  op_e                     cmd_op,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES-1:0]        cmd_be,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    q_valid,
  output logic                    ev_commit,
  output logic                    ev_fwd
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_a, s2_a, lw_a;
  logic [LANES-1:0]  s1_be, s2_be, lw_be, hit;
  logic              lw_v;
  logic [DW-1:0]     lw_d, rbuf, merged;
  logic [DW-1:0]     mem [DEPTH];

  // Lane-wise merge of the write committed one edge earlier.
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign hit[g] = lw_v && (lw_a == s2_a) && lw_be[g];
    assign merged[g*LANE_W +: LANE_W] =
      hit[g] ? lw_d[g*LANE_W +: LANE_W] : rbuf[g*LANE_W +: LANE_W];
  end

  assign ev_commit = en && (s2_op == OP_WR) && (|s2_be);
  assign ev_fwd    = en && (s2_op == OP_RD) && (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_a    <= '0;
      s2_a    <= '0;
      s1_be   <= '0;
      s2_be   <= '0;
      lw_v    <= 1'b0;
      lw_a    <= '0;
      lw_be   <= '0;
      lw_d    <= '0;
      q_valid <= 1'b0;
      rdata   <= '0;
    end else if (en) begin
      s1_op   <= cmd_op;
      s1_a    <= cmd_addr;
      s1_be   <= cmd_be;
      s2_op   <= s1_op;
      s2_a    <= s1_a;
      s2_be   <= s1_be;
      lw_v    <= (s2_op == OP_WR);
      lw_a    <= s2_a;
      lw_be   <= s2_be;
      lw_d    <= wdata;
      q_valid <= (s2_op == OP_RD);
      if (s2_op == OP_RD) rdata <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      rbuf <= mem[s1_a];
      if (s2_op == OP_WR) begin
        for (int l = 0; l < LANES; l++) begin
          if (s2_be[l]) mem[s2_a][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
      end
    end
  end

endmodule

// File: rtl/tsram_top.sv
module tsram_top
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    adv,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    order_il,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_valid
);

  logic              en, sel_ok, asleep, q_valid;
  logic [1:0]        sleep_q;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_be;
  logic              ev_load, ev_adv, ev_commit, ev_fwd;

  assign en       = !hold;
  assign sel_ok   = !sel_a_n && sel_b && !sel_c_n;
  assign asleep   = sleep_q[1];
  assign rd_valid = q_valid && !asleep;

  // Two-stage sleep delay, clocked independently of hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= '0;
    else        sleep_q <= {sleep_q[0], sleep};
  end

  tsram_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) i_burst (
    .clk(clk), .rst_n(rst_n), .en(en), .asleep(asleep), .sel_ok(sel_ok),
    .adv(adv), .wr_n(wr_n), .order_il(order_il), .lanes_n(lane_n),
    .addr(addr), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .ev_load(ev_load), .ev_adv(ev_adv)
  );

  tsram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_pipe (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_be(cmd_be), .wdata(wdata), .rdata(rdata), .q_valid(q_valid),
    .ev_commit(ev_commit), .ev_fwd(ev_fwd)
  );

endmodule

// File: rtl/tsram_chk.sv
module tsram_chk
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              adv,
  input logic              sleep,
  input logic              order_il,
  input logic              sel_ok,
  input logic              asleep,
  input op_e               cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              q_valid,
  input logic              rd_valid,
  input logic [DW-1:0]     rdata
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_RD && !hold) ##1 !hold ##1 !hold |=> q_valid); // R1

  AST_DESEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !sel_ok && !hold && !asleep) ##1 (adv && !asleep) |-> (cmd_op == OP_IDLE)); // R4

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != OP_IDLE && !hold && !order_il) ##1 (adv && !asleep && !order_il) |->
      (cmd_addr[1:0] == $past(cmd_addr[1:0]) + 2'd1) &&
      (cmd_addr[ADDR_W-1:2] == $past(cmd_addr[ADDR_W-1:2]))); // R5

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(rdata) && $stable(q_valid)); // R7

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep, 2) |-> !rd_valid); // R8

endmodule

bind tsram_top tsram_chk #(.ADDR_W(ADDR_W), .DW(LANES*LANE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .adv(adv), .sleep(sleep),
  .order_il(order_il), .sel_ok(sel_ok), .asleep(asleep), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .q_valid(q_valid), .rd_valid(rd_valid), .rdata(rdata)
);

// File: tb/test_tsram_top.sv
module test_tsram_top;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 8;
  localparam int DW = LN * LW;

  logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, adv = 1'b0, wr_n = 1'b1;
  logic [LN-1:0] lane_n = '1;
  logic order_il = 1'b0, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rd_valid;

  int tests = 0, fails = 0;
  bit done = 0;

  // Bench reference state
  logic [DW-1:0] ref_mem [1<<AW];
  int bop = 0, bbeat = 0, p1op = 0, p2op = 0;
  logic [AW-1:0] bbase = '0, p1a = '0, p2a = '0;
  logic [LN-1:0] p1be = '0, p2be = '0;
  logic sq0 = 1'b0, sq1 = 1'b0, ev = 1'b0;
  logic [DW-1:0] ed = '0;

  always #2 clk = ~clk;

  tsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_tsram_top (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .wr_n(wr_n), .lane_n(lane_n),
    .order_il(order_il), .sleep(sleep), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  function automatic logic [1:0] order_of(input logic [1:0] s, input int b, input logic il);
    logic [1:0] bb;
    bb = b[1:0];
    if (il) return {s[1] ^ bb[1], s[0] ^ bb[0]};
    return 2'((int'(s) + b) % 4);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic h, input logic s1n, input logic s2, input logic s3n,
                      input logic ad, input logic wn, input logic [LN-1:0] ln,
                      input logic slp, input logic [AW-1:0] a, input string tag);
    logic was_asleep;
    int cop;
    logic [AW-1:0] ca;
    logic [LN-1:0] cbe;
    hold = h; sel_a_n = s1n; sel_b = s2; sel_c_n = s3n; adv = ad; wr_n = wn;
    lane_n = ln; sleep = slp; addr = a; wdata = $urandom;
    was_asleep = sq1;
    cop = 0; ca = a;
    if (!was_asleep && !ad) cop = (!s1n && s2 && !s3n) ? (wn ? 1 : 2) : 0;
    else if (!was_asleep && ad) begin
      cop = bop;
      ca = {bbase[AW-1:2], order_of(bbase[1:0], bbeat + 1, order_il)};
    end
    cbe = (cop == 2) ? ~ln : '0;
    if (!h) begin
      if (p2op == 2)
        for (int l = 0; l < LN; l++)
          if (p2be[l]) ref_mem[p2a][l*LW +: LW] = wdata[l*LW +: LW];
      ev = (p2op == 1);
      if (p2op == 1) ed = ref_mem[p2a];
      p2op = p1op; p2a = p1a; p2be = p1be;
      p1op = cop; p1a = ca; p1be = cbe;
      if (!was_asleep) begin
        if (!ad) begin bop = cop; bbase = a; bbeat = 0; end
        else if (bop != 0) bbeat = (bbeat + 1) % 4;
      end
    end
    sq1 = sq0; sq0 = slp;
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, DW'(rd_valid), DW'(ev && !sq1));
    if (ev && !sq1) check({tag, " data"}, rdata, ed);
  endtask

  // Shorthands (unit active select)
  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] ln, input string t);
    step(0, 0, 1, 0, 0, 0, ln, 0, a, t);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string t);
    step(0, 0, 1, 0, 0, 1, '1, 0, a, t);
  endtask
  task automatic nxt(input logic [LN-1:0] ln, input string t);
    step(0, 0, 1, 0, 1, 1, ln, 0, '0, t);
  endtask
  task automatic idle(input string t);
    step(0, 1, 1, 0, 0, 1, '1, 0, '0, t);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 reset valid", DW'(rd_valid), '0);
    // R9: advance straight after reset is a deselect and writes nothing
    step(0, 0, 1, 0, 1, 0, '0, 0, '0, "R9");
    idle("R9");
    // Fill memory with full-lane writes (R2)
    for (int i = 0; i < (1 << AW); i++) wr(AW'(i), '0, "R2 fill");
    idle("R2"); idle("R2");
    for (int i = 0; i < 8; i++) rd(AW'(i), "R2 readback");
    // R6: read right behind a write to the same word, and partial lanes
    wr(5, '0, "R6"); rd(5, "R6 forward"); rd(5, "R6");
    wr(5, 4'b1010, "R6 lanes"); rd(5, "R6 lane forward");
    rd(9, "R6"); wr(9, 4'b0110, "R6"); rd(9, "R6"); wr(10, '0, "R6"); rd(10, "R6");
    // R3: write abort leaves the word intact
    wr(7, '1, "R3 abort"); nxt('1, "R3 abort beat"); rd(7, "R3"); rd(4, "R3");
    idle("R3"); idle("R3");
    // R4: deselect combinations and the advance cycles after them
    step(0, 1, 1, 0, 0, 0, '0, 0, 12, "R4");
    step(0, 0, 1, 0, 1, 0, '0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, '0, 0, 13, "R4");
    step(0, 0, 1, 1, 0, 0, '0, 0, 14, "R4");
    step(0, 0, 1, 0, 1, 0, '0, 0, 0, "R4");
    rd(12, "R4"); rd(13, "R4"); rd(14, "R4"); rd(0, "R4");
    // R5: linear burst with wrap, then interleaved write and read bursts
    rd(6, "R5 linear"); nxt('1, "R5"); nxt('1, "R5"); nxt('1, "R5"); nxt('1, "R5 wrap");
    order_il = 1'b1;
    wr(21, '0, "R5 il"); nxt('0, "R5"); nxt(4'b1100, "R5"); nxt('0, "R5");
    rd(21, "R5 il"); nxt('1, "R5"); nxt('1, "R5"); nxt('1, "R5");
    idle("R5"); idle("R5");
    order_il = 1'b0;
    // R7: suspend in the middle of a read and a write
    rd(3, "R7"); step(1, 0, 1, 0, 0, 0, '0, 0, 3, "R7 hold");
    step(1, 0, 1, 0, 0, 0, '0, 0, 3, "R7 hold"); nxt('1, "R7");
    wr(30, '0, "R7"); step(1, 1, 1, 1, 0, 0, '0, 0, 30, "R7 hold"); rd(30, "R7");
    step(1, 1, 1, 1, 1, 0, '0, 0, 0, "R7 hold"); idle("R7"); idle("R7"); idle("R7");
    // R8: sleep entry and exit
    rd(2, "R8"); step(0, 0, 1, 0, 0, 1, '1, 1, 2, "R8 enter");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, i[0], '0, 1, AW'(40 + i), "R8 asleep");
    step(0, 0, 1, 0, 0, 1, '1, 0, 2, "R8 exit");
    step(0, 0, 1, 0, 0, 1, '1, 0, 2, "R8 exit");
    rd(40, "R8 awake"); rd(41, "R8 awake"); idle("R8"); idle("R8"); idle("R8");
    // Random mix in both orders (R1, R2, R5, R6)
    for (int ph = 0; ph < 2; ph++) begin
      order_il = ph[0];
      idle("R6");
      for (int i = 0; i < 1500; i++) begin
        r = $urandom % 8;
        step(($urandom % 10) == 0, r == 6, r != 7, 1'b0, ($urandom % 5) < 2,
             $urandom % 2, (($urandom % 6) == 0) ? '1 : LN'($urandom), 1'b0,
             AW'($urandom), "R6 random");
      end
    end
    idle("R1"); idle("R1"); idle("R1");
    done = 1;
    summary();
    $finish;
  end

endmodule